// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises host software with a window watchdog. Once armed, the host must restart it no sooner than a programmed minimum time and no later than a programmed maximum time. A restart comes from writing a fixed 4-bit key to a dedicated register address. A restart that comes too early raises an early-fault flag. A missing restart raises a late-fault flag. Either fault sends a one-cycle reset request to the system supervisor when the enable bit is set. Time advances only on a one-millisecond tick input, so the block runs from any core clock.

The host writes the lower bound and the upper bound as 5-bit step counts. These values sit in holding registers until the next accepted key write, which copies them into the running timer. An upper bound of zero stops the timer. While the supply monitor reports that the supply is below the trip point, the timer is forced idle. After a fault that requested a reset, the timer waits for the supervisor's reset-release pulse and then starts a fresh window.

Top module: `window_watchdog`

## Requirements
- R1: After synchronous reset, reset_req, flag_early, flag_late and timer_running are 0, and both active bounds are zero, so the timer stays stopped.
- R2: A write with wr_sel = 2 restarts the timer only when wr_data[3:0] equals 4'b1010, whatever wr_data[7:4] holds. Any other low nibble leaves the count untouched.
- R3: wr_sel = 0 writes the lower bound (wr_data[4:0]) and wr_sel = 1 writes the upper bound (wr_data[4:0]). These values govern the timer only from the next accepted key write onward.
- R4: When the upper bound times END_STEP ticks have elapsed since the last restart with no new restart, flag_late is set. If enabled, reset_req pulses.
- R5: A key write while running, after fewer than the lower bound times START_STEP ticks since the last restart, sets flag_early and pulses reset_req if enabled. A key write at or after that bound restarts the window cleanly.
- R6: The enable bit is wr_data[7] of the wr_sel = 1 write and acts at once. When it is clear, faults still set their flags and the timer starts a new window by itself, but reset_req stays 0.
- R7: With an active upper bound of zero, timer_running is 0 and no fault is raised.
- R8: While supply_low is high, the timer is stopped with its count cleared and reset_req stays 0. Key writes during that time only load the settings. Counting resumes from zero once supply_low falls.
- R9: After a fault that pulsed reset_req, the timer holds with timer_running at 0 and ignores key writes. It resumes from a zero count on a pulse of rst_release.
- R10: A write with wr_sel = 3 clears flag_early for wr_data[1] = 1 and flag_late for wr_data[0] = 1. A 0 bit leaves its flag alone, and a new fault in the same cycle wins over the clear.
- R11: reset_req is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per millisecond |
| supply_low | input | 1 | Supply below trip point; forces the timer idle |
| rst_release | input | 1 | Pulse at the end of the supervisor's reset pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 lower bound, 1 upper bound and enable, 2 key, 3 flag clear |
| wr_data | input | DATA_W | Write data |
| reset_req | output | 1 | One-cycle reset request to the supervisor |
| flag_early | output | 1 | Early-restart fault flag |
| flag_late | output | 1 | Missed-restart fault flag |
| timer_running | output | 1 | Timer is counting a window |

## Verification
The bench places key writes one tick before, exactly on, and after the lower bound. A design with an off-by-one compare there would flag a legal restart or accept an early one. It stops one tick short of the upper bound and then takes the final tick, which catches a timeout that fires a tick early or late. It writes new bounds without a key and times the old window, which exposes a design that applies settings at once. It also drives a wrong key nibble and a key with junk in the upper nibble, a key during the post-fault hold, and a supply drop in the middle of a window. A design that restarted on any key, ignored the hold, or kept counting through the supply drop would show a fault flag or reset count that differs from the expected value.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    localparam int unsigned CFG_W   = 5;
    localparam int unsigned KEY_W   = 4;
    localparam logic [KEY_W-1:0] RESTART_KEY = 4'b1010;
    localparam int unsigned CFG_MAX = (1 << CFG_W) - 1;

    typedef enum logic [1:0] {
        SEL_LOWER = 2'd0,
        SEL_UPPER = 2'd1,
        SEL_KEY   = 2'd2,
        SEL_FLAGS = 2'd3
    } wd_sel_e;

    typedef enum logic [1:0] {
        WD_STOP = 2'd0,
        WD_RUN  = 2'd1,
        WD_HOLD = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic [CFG_W-1:0] lower;
        logic [CFG_W-1:0] upper;
    } wd_bounds_t;

    typedef struct packed {
        logic early;
        logic late;
        logic req;
    } wd_event_t;

    function automatic int unsigned span_ticks(input logic [CFG_W-1:0] steps,
                                               input int unsigned step_len);
        return int'(steps) * step_len;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdw_key_match.sv
module wdw_key_match
    import wdw_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_hit
);

    logic sel_is_key;
    logic nib_ok;

    assign sel_is_key = wr_en && (wd_sel_e'(wr_sel) == SEL_KEY);
    assign nib_ok     = (wr_data[KEY_W-1:0] == RESTART_KEY);
    assign key_hit    = sel_is_key && nib_ok;

endmodule

// File: rtl/wdw_cfg_regs.sv
module wdw_cfg_regs
    import wdw_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  wd_event_t         evt,
    output wd_bounds_t        bounds_pend,
    output wd_bounds_t        bounds_act,
    output logic              enable,
    output logic              flag_early,
    output logic              flag_late
);

    localparam int unsigned EN_BIT    = DATA_W - 1;
    localparam int unsigned CLR_LATE  = 0;
    localparam int unsigned CLR_EARLY = 1;

    wd_sel_e    sel;
    wd_bounds_t pend_q;
    wd_bounds_t act_q;
    logic       en_q;
    logic       early_q;
    logic       late_q;
    logic       clr_early;
    logic       clr_late;

    assign sel       = wd_sel_e'(wr_sel);
    assign clr_early = wr_en && (sel == SEL_FLAGS) && wr_data[CLR_EARLY];
    assign clr_late  = wr_en && (sel == SEL_FLAGS) && wr_data[CLR_LATE];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= 1'b0;
        end else if (wr_en) begin
            if (sel == SEL_LOWER) begin
                pend_q.lower <= wr_data[CFG_W-1:0];
            end
            if (sel == SEL_UPPER) begin
                pend_q.upper <= wr_data[CFG_W-1:0];
                en_q         <= wr_data[EN_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (load) begin
            act_q <= pend_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            early_q <= 1'b0;
            late_q  <= 1'b0;
        end else begin
            if (evt.early) begin
                early_q <= 1'b1;
            end else if (clr_early) begin
                early_q <= 1'b0;
            end
            if (evt.late) begin
                late_q <= 1'b1;
            end else if (clr_late) begin
                late_q <= 1'b0;
            end
        end
    end

    assign bounds_pend = pend_q;
    assign bounds_act  = act_q;
    assign enable      = en_q;
    assign flag_early  = early_q;
    assign flag_late   = late_q;

endmodule

// File: rtl/wdw_core.sv
module wdw_core
    import wdw_pkg::*;
#(
    parameter int unsigned START_STEP = 25,
    parameter int unsigned END_STEP   = 60,
    parameter int unsigned CNT_W      = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       supply_low,
    input  logic       rst_release,
    input  logic       key_hit,
    input  logic       enable,
    input  wd_bounds_t bounds_pend,
    input  wd_bounds_t bounds_act,
    output logic       load,
    output wd_event_t  evt,
    output logic       running
);

    wd_state_e        st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    wd_event_t        evt_q, evt_n;
    logic [CNT_W-1:0] lower_lim;
    logic [CNT_W-1:0] upper_lim;
    logic [CNT_W:0]   cnt_inc;
    logic             pend_armed;
    logic             act_armed;
    logic             too_soon;
    logic             expired;

    assign lower_lim  = CNT_W'(span_ticks(bounds_act.lower, START_STEP));
    assign upper_lim  = CNT_W'(span_ticks(bounds_act.upper, END_STEP));
    assign cnt_inc    = {1'b0, cnt_q} + (CNT_W+1)'(1);
    assign pend_armed = (bounds_pend.upper != '0);
    assign act_armed  = (bounds_act.upper != '0);
    assign too_soon   = (st_q == WD_RUN) && (cnt_q < lower_lim);
    assign expired    = (cnt_inc >= {1'b0, upper_lim});

    // settings may be latched during a supply drop, never during the hold
    assign load = key_hit && (st_q != WD_HOLD);

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        evt_n = '0;
        if (supply_low) begin
            st_n  = WD_STOP;
            cnt_n = '0;
        end else if (load) begin
            cnt_n = '0;
            st_n  = pend_armed ? WD_RUN : WD_STOP;
            if (too_soon) begin
                evt_n.early = 1'b1;
                if (enable) begin
                    evt_n.req = 1'b1;
                    st_n      = WD_HOLD;
                end
            end
        end else begin
            unique case (st_q)
                WD_RUN: begin
                    if (!act_armed) begin
                        st_n  = WD_STOP;
                        cnt_n = '0;
                    end else if (tick) begin
                        if (expired) begin
                            evt_n.late = 1'b1;
                            cnt_n      = '0;
                            if (enable) begin
                                evt_n.req = 1'b1;
                                st_n      = WD_HOLD;
                            end
                        end else begin
                            cnt_n = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                WD_HOLD: begin
                    if (rst_release) begin
                        cnt_n = '0;
                        st_n  = act_armed ? WD_RUN : WD_STOP;
                    end
                end
                default: begin
                    if (act_armed) begin
                        st_n  = WD_RUN;
                        cnt_n = '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WD_STOP;
            cnt_q <= '0;
            evt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            evt_q <= evt_n;
        end
    end

    assign evt     = evt_q;
    assign running = (st_q == WD_RUN);

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
    import wdw_pkg::*;
#(
    parameter int unsigned START_STEP = 25,
    parameter int unsigned END_STEP   = 60,
    parameter int unsigned DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              supply_low,
    input  logic              rst_release,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              reset_req,
    output logic              flag_early,
    output logic              flag_late,
    output logic              timer_running
);

    localparam int unsigned LIM_MAX = CFG_MAX * max_u(START_STEP, END_STEP);
    localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);

    logic       key_hit;
    logic       load;
    logic       enable;
    wd_bounds_t bounds_pend;
    wd_bounds_t bounds_act;
    wd_event_t  evt;

    wdw_key_match #(
        .DATA_W (DATA_W)
    ) u_key (
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .key_hit (key_hit)
    );

    wdw_cfg_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .load        (load),
        .evt         (evt),
        .bounds_pend (bounds_pend),
        .bounds_act  (bounds_act),
        .enable      (enable),
        .flag_early  (flag_early),
        .flag_late   (flag_late)
    );

    wdw_core #(
        .START_STEP (START_STEP),
        .END_STEP   (END_STEP),
        .CNT_W      (CNT_W)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .supply_low  (supply_low),
        .rst_release (rst_release),
        .key_hit     (key_hit),
        .enable      (enable),
        .bounds_pend (bounds_pend),
        .bounds_act  (bounds_act),
        .load        (load),
        .evt         (evt),
        .running     (timer_running)
    );

    assign reset_req = evt.req;

endmodule

// File: rtl/wdw_checker.sv
module wdw_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              supply_low,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              reset_req,
    input logic              flag_early,
    input logic              flag_late,
    input logic              timer_running
);

    logic key_now;
    assign key_now = wr_en && (wr_sel == 2'd2) && (wr_data[3:0] == 4'b1010);

    // R11: the request never lasts longer than one cycle
    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    // R4 / R5: every request leaves a fault flag behind
    assert_req_flags_R4: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> (flag_early || flag_late));

    // R8: a low supply silences the timer on the next cycle
    assert_supply_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        supply_low |=> (!timer_running && !reset_req));

    // R5: an early fault can only follow a valid key write
    assert_early_from_key_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_early) |-> $past(key_now, 2));

    // R4: a late fault needs a tick and a healthy supply
    assert_late_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_late) |-> ($past(tick, 2) && !$past(supply_low, 2)));

endmodule

bind window_watchdog wdw_checker #(
    .DATA_W (DATA_W)
) u_wdw_chk (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .supply_low    (supply_low),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .reset_req     (reset_req),
    .flag_early    (flag_early),
    .flag_late     (flag_late),
    .timer_running (timer_running)
);

// File: tb/window_watchdog_bench.sv
module window_watchdog_bench;

    localparam int unsigned SSTEP  = 2;
    localparam int unsigned ESTEP  = 5;
    localparam int unsigned DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              supply_low = 1'b0;
    logic              rst_release = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_sel = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              reset_req;
    logic              flag_early;
    logic              flag_late;
    logic              timer_running;

    int n_chk = 0;
    int n_bad = 0;
    int req_cnt = 0;
    int req_run = 0;
    int req_run_max = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    window_watchdog #(
        .START_STEP (SSTEP),
        .END_STEP   (ESTEP),
        .DATA_W     (DATA_W)
    ) u_window_watchdog (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .supply_low    (supply_low),
        .rst_release   (rst_release),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .reset_req     (reset_req),
        .flag_early    (flag_early),
        .flag_late     (flag_late),
        .timer_running (timer_running)
    );

    always @(negedge clk) begin
        if (reset_req) begin
            req_cnt++;
            req_run++;
            if (req_run > req_run_max) req_run_max = req_run;
        end else begin
            req_run = 0;
        end
    end

    // vector table: lower, upper, enable, ticks, key after ticks, expected early/late/requests
    localparam int NV = 9;
    localparam int V_S [NV] = '{3, 3, 3, 3,  3,  0, 3, 3, 3};
    localparam int V_E [NV] = '{2, 2, 2, 2,  2,  1, 2, 2, 2};
    localparam int V_EN[NV] = '{1, 1, 0, 1,  0,  1, 1, 1, 1};
    localparam int V_N [NV] = '{8, 4, 4, 10, 10, 0, 6, 5, 9};
    localparam int V_K [NV] = '{1, 1, 1, 0,  0,  1, 1, 1, 0};
    localparam int V_XE[NV] = '{0, 1, 1, 0,  0,  0, 0, 1, 0};
    localparam int V_XL[NV] = '{0, 0, 0, 1,  1,  0, 0, 0, 0};
    localparam int V_XR[NV] = '{0, 1, 0, 1,  0,  0, 0, 1, 0};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [DATA_W-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic prep(input int s, input int e, input int en);
        @(negedge clk); supply_low = 1'b1;
        repeat (2) @(negedge clk);
        wr(2'd0, DATA_W'(s));
        wr(2'd1, {en[0], 2'b00, e[4:0]});
        wr(2'd2, 8'h0A);
        wr(2'd3, 8'h03);
        @(negedge clk); supply_low = 1'b0;
        @(negedge clk);
        req_cnt = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset_req", int'(reset_req), 0);
        chk("R1 flag_early", int'(flag_early), 0);
        chk("R1 flag_late", int'(flag_late), 0);
        repeat (3) @(negedge clk);
        chk("R1 timer stopped", int'(timer_running), 0);

        // table walk: R4 timeout, R5 early/boundary, R6 disabled behaviour
        for (int v = 0; v < NV; v++) begin
            prep(V_S[v], V_E[v], V_EN[v]);
            ticks(V_N[v]);
            if (V_K[v] != 0) wr(2'd2, 8'h0A);
            settle();
            chk($sformatf("R4/R5/R6 vec %0d early", v), int'(flag_early), V_XE[v]);
            chk($sformatf("R4/R5/R6 vec %0d late", v), int'(flag_late), V_XL[v]);
            chk($sformatf("R4/R5/R6 vec %0d requests", v), req_cnt, V_XR[v]);
        end

        // R2: a wrong nibble neither restarts nor faults
        prep(3, 2, 1);
        ticks(4);
        wr(2'd2, 8'h05);
        settle();
        chk("R2 wrong key no early", int'(flag_early), 0);
        ticks(6);
        settle();
        chk("R2 wrong key no restart", int'(flag_late), 1);
        chk("R2 wrong key request", req_cnt, 1);

        // R2: upper nibble is don't-care
        prep(3, 2, 0);
        ticks(7);
        wr(2'd2, 8'hFA);
        ticks(7);
        settle();
        chk("R2 upper nibble key restarts", int'(flag_late), 0);
        ticks(3);
        settle();
        chk("R2 new window expires", int'(flag_late), 1);

        // R3: new bound waits for the key
        prep(3, 2, 0);
        wr(2'd1, 8'h04);
        ticks(10);
        settle();
        chk("R3 old bound still used", int'(flag_late), 1);
        wr(2'd3, 8'h03);
        wr(2'd2, 8'h0A);
        settle();
        chk("R3 key right after restart is early", int'(flag_early), 1);
        wr(2'd3, 8'h03);
        ticks(19);
        settle();
        chk("R3 new bound not yet expired", int'(flag_late), 0);
        ticks(1);
        settle();
        chk("R3 new bound expires", int'(flag_late), 1);

        // R7: upper bound zero stops the timer
        prep(0, 0, 1);
        settle();
        chk("R7 stopped", int'(timer_running), 0);
        ticks(50);
        settle();
        chk("R7 no late", int'(flag_late), 0);
        chk("R7 no request", req_cnt, 0);

        // R8: supply drop mid-window
        prep(0, 2, 1);
        ticks(8);
        @(negedge clk); supply_low = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 stopped while low", int'(timer_running), 0);
        ticks(5);
        @(negedge clk); supply_low = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 resumes", int'(timer_running), 1);
        ticks(9);
        settle();
        chk("R8 count restarted from zero", int'(flag_late), 0);
        ticks(1);
        settle();
        chk("R8 expiry after resume", int'(flag_late), 1);
        chk("R8 request count", req_cnt, 1);

        // R9: hold until release
        settle();
        chk("R9 holding", int'(timer_running), 0);
        wr(2'd3, 8'h03);
        wr(2'd2, 8'h0A);
        settle();
        chk("R9 key ignored in hold", int'(timer_running), 0);
        ticks(20);
        settle();
        chk("R9 no late during hold", int'(flag_late), 0);
        chk("R9 no extra request", req_cnt, 1);
        @(negedge clk); rst_release = 1'b1;
        @(negedge clk); rst_release = 1'b0;
        @(negedge clk);
        chk("R9 running after release", int'(timer_running), 1);
        ticks(9);
        settle();
        chk("R9 fresh window", int'(flag_late), 0);
        ticks(1);
        settle();
        chk("R9 fresh window expires", int'(flag_late), 1);

        // R10: write-one-to-clear
        prep(3, 2, 0);
        ticks(4);
        wr(2'd2, 8'h0A);
        ticks(10);
        settle();
        chk("R10 both flags set (early)", int'(flag_early), 1);
        chk("R10 both flags set (late)", int'(flag_late), 1);
        wr(2'd3, 8'h00);
        settle();
        chk("R10 zero write keeps early", int'(flag_early), 1);
        chk("R10 zero write keeps late", int'(flag_late), 1);
        wr(2'd3, 8'h02);
        settle();
        chk("R10 clear early only", int'(flag_early), 0);
        chk("R10 late untouched", int'(flag_late), 1);
        wr(2'd3, 8'h01);
        settle();
        chk("R10 clear late", int'(flag_late), 0);

        // R11: pulse width seen across the whole run
        chk("R11 request width", req_run_max, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule